// File: doc/BRIEF.md
# Scalar DSP Miscellaneous Execute Unit

This block is the execute stage for a group of scalar DSP helper operations on a 32-bit RISC-V core. All of them sit in the custom major opcode `1111111`. Each cycle the unit takes one instruction word and the operands the core has already read: up to three source registers, the present value of the destination register, and the register that follows rs1 (for operations on a register pair). It returns the result, a write-enable for the destination, and a flag that marks an encoding in this opcode as undefined.

The operations are:

- a rounding average that cannot overflow;
- an arithmetic right shift that rounds halves upward;
- a reversal of a variable-length low bit field;
- extraction of a 32-bit window from a 64-bit register pair;
- a per-bit select between two registers under a mask register;
- replacement of one byte of the destination;
- a 32-bit multiply-accumulate and a 32-bit multiply-subtract.

Decode and computation are combinational. A parameter `OUT_REG` (default 1) adds one register stage on the three outputs, so that results appear on the cycle after the instruction is presented.

Top module: `dspmisc_alu`

## Requirements
- R1: Each defined encoding, presented with `inValid` high, drives `writeEn` high and `illegal` low. The defined encodings all have opcode bits 6:0 = 1111111 and are decoded on bits 31:25 (f7) and 14:12 (f3), as listed in R2 to R8.
- R2: f7=1110000, f3=000 yields the signed average floor((rs1+rs2+1)/2). It is computed at full precision, so there is no overflow even for the most-negative and most-positive pairs.
- R3: The rounding shift uses either f7=0010010, f3=001 (amount from rs2) or bits 31:26=110101, f3=001 (amount from bits 24:20). Only the low 5 bits of the amount count. The result is rs1 shifted arithmetically right, plus the last bit shifted out. An amount of 0 returns rs1 unchanged.
- R4: Bit reverse uses either f7=1110011, f3=000 (amount s from rs2) or bits 31:26=111010, f3=000 (s from bits 24:20). It places bits s..0 of rs1 in reversed order into result bits 0..s, and all higher result bits are zero.
- R5: Word extract uses either f7=1100111, f3=000 (position from rs2[4:0]) or f7=1101111, f3=000 (position from bits 24:20). It returns bits p+31..p of the 64-bit value {next register, rs1}.
- R6: Bit-pick uses f3=011 with bits 26:25=00, and takes rs3 from bits 31:27. The result is (rs3 & rs1) | (~rs3 & rs2).
- R7: Byte insert uses bits 31:23=101011000 with f3=000. It writes rs1[7:0] into byte number bits 21:20 of the current rd value and leaves the other three bytes unchanged.
- R8: f7=1100010, f3=001 returns rd + rs1*rs2, and f7=1100011, f3=001 returns rd - rs1*rs2. Both results are truncated to 32 bits.
- R9: Any other encoding under opcode 1111111, including f3=011 with bits 26:25 not 00, drives `illegal` high and `writeEn` low. Whenever `writeEn` is low, `result` is zero.
- R10: An instruction whose opcode is not 1111111, or any cycle with `inValid` low, drives both `writeEn` and `illegal` low.
- R11: With `OUT_REG`=1, all three outputs show the instruction presented on the previous clock edge, and an active-low reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Instruction word and operands are valid |
| insn | input | 32 | Instruction word |
| opA | input | 32 | rs1 value |
| opB | input | 32 | rs2 value |
| opC | input | 32 | rs3 value (bit-pick mask) |
| rdOld | input | 32 | Current destination register value |
| opAHi | input | 32 | Value of the register after rs1 (high word of the pair) |
| result | output | 32 | Value to write to rd |
| writeEn | output | 1 | Destination write strobe |
| illegal | output | 1 | Undefined encoding in this opcode |

## Verification
The cases random operands almost never reach are the ones where a carry or a boundary decides the result. Examples are the rounding shift at amount 31, where the single kept bit plus the rounding bit can carry; the average at the extreme signed pairs; and word extraction at positions 0 and 31, which straddle the register-pair boundary. The stimulus drives these as directed operand pairs, and then sends several thousand random instruction words through the behavioural model. The random words are biased toward each encoding class, including the bit-pick variants with non-zero bits 26:25 and opcodes outside the group.

// File: rtl/dspmisc_pkg.sv
package dspmisc_pkg;
  localparam int XLEN  = 32;
  localparam int SHW   = $clog2(XLEN);
  localparam int NBYTE = XLEN / 8;
  localparam int BSW   = $clog2(NBYTE);

  localparam logic [6:0] MAJOR_OP = 7'b1111111;

  typedef enum logic [2:0] {
    OP_AVG, OP_RSHIFT, OP_BREV, OP_WEXT, OP_BPICK, OP_INSB, OP_MAC, OP_MSUB
  } opKind_e;

  typedef struct packed {
    logic           wen;
    logic           illegal;
    opKind_e        kind;
    logic           useImm;
    logic [SHW-1:0] immAmt;
    logic [BSW-1:0] byteSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/dspmisc_ctrl.sv
module dspmisc_ctrl
  import dspmisc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] insn,
  output ctrlStrobe_t strobe
);
  logic [6:0] f7;
  logic [2:0] f3;
  logic       ours;
  logic       unusedRegFields;

  assign f7   = insn[31:25];
  assign f3   = insn[14:12];
  assign ours = inValid && (insn[6:0] == MAJOR_OP);
  assign unusedRegFields = ^{insn[19:15], insn[11:7]};

  always_comb begin
    logic hit;
    strobe         = '0;
    strobe.immAmt  = insn[20 +: SHW];
    strobe.byteSel = insn[20 +: BSW];
    hit            = 1'b1;
    if (f3 == 3'b011) begin
      hit         = (insn[26:25] == 2'b00);
      strobe.kind = OP_BPICK;
    end else if (f7 == 7'b1110000 && f3 == 3'b000) begin
      strobe.kind = OP_AVG;
    end else if (f7 == 7'b0010010 && f3 == 3'b001) begin
      strobe.kind = OP_RSHIFT;
    end else if (f7[6:1] == 6'b110101 && f3 == 3'b001) begin
      strobe.kind   = OP_RSHIFT;
      strobe.useImm = 1'b1;
    end else if (f7 == 7'b1110011 && f3 == 3'b000) begin
      strobe.kind = OP_BREV;
    end else if (f7[6:1] == 6'b111010 && f3 == 3'b000) begin
      strobe.kind   = OP_BREV;
      strobe.useImm = 1'b1;
    end else if (f7 == 7'b1100111 && f3 == 3'b000) begin
      strobe.kind = OP_WEXT;
    end else if (f7 == 7'b1101111 && f3 == 3'b000) begin
      strobe.kind   = OP_WEXT;
      strobe.useImm = 1'b1;
    end else if (insn[31:23] == 9'b101011000 && f3 == 3'b000) begin
      strobe.kind = OP_INSB;
    end else if (f7 == 7'b1100010 && f3 == 3'b001) begin
      strobe.kind = OP_MAC;
    end else if (f7 == 7'b1100011 && f3 == 3'b001) begin
      strobe.kind = OP_MSUB;
    end else begin
      hit = 1'b0;
    end
    strobe.wen     = ours && hit;
    strobe.illegal = ours && !hit;
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wen && strobe.illegal));
  assert_foreign_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (insn[6:0] != MAJOR_OP || !inValid) |-> (!strobe.wen && !strobe.illegal));
  assert_bpick_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insn[6:0] == MAJOR_OP && f3 == 3'b011 && insn[26:25] != 2'b00)
      |-> strobe.illegal);
endmodule

// File: rtl/dspmisc_dp.sv
module dspmisc_dp
  import dspmisc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] opC,
  input  logic [XLEN-1:0] rdOld,
  input  logic [XLEN-1:0] opAHi,
  output logic [XLEN-1:0] result
);
  localparam logic [SHW-1:0] MAXAMT = SHW'(XLEN - 1);

  logic [SHW-1:0]        amt;
  logic [XLEN:0]         avgSum;
  logic signed [XLEN:0]  rshExt;
  logic [XLEN-1:0]       rshRes;
  logic [XLEN-1:0]       revA;
  logic [XLEN-1:0]       brevRes;
  logic [2*XLEN-1:0]     pairShift;
  logic [XLEN-1:0]       bpickRes;
  logic [XLEN-1:0]       insbRes;
  logic [XLEN-1:0]       prodLo;
  logic [XLEN-1:0]       selRes;

  assign amt = strobe.useImm ? strobe.immAmt : opB[SHW-1:0];

  // average at one extra bit of precision: no overflow possible
  assign avgSum = {opA[XLEN-1], opA} + {opB[XLEN-1], opB} + (XLEN+1)'(1);

  // keep one guard bit below the LSB; it is the rounding increment
  assign rshExt = $signed({opA, 1'b0}) >>> amt;
  assign rshRes = rshExt[XLEN:1] + XLEN'(rshExt[0]);

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign revA[i] = opA[XLEN-1-i];
  end
  assign brevRes = revA >> (MAXAMT - amt);

  assign pairShift = {opAHi, opA} >> amt;

  assign bpickRes = (opC & opA) | (~opC & opB);

  for (genvar k = 0; k < NBYTE; k++) begin : g_insb
    assign insbRes[8*k +: 8] = (strobe.byteSel == BSW'(k)) ? opA[7:0] : rdOld[8*k +: 8];
  end

  assign prodLo = opA * opB;

  always_comb begin
    unique case (strobe.kind)
      OP_AVG:    selRes = avgSum[XLEN:1];
      OP_RSHIFT: selRes = rshRes;
      OP_BREV:   selRes = brevRes;
      OP_WEXT:   selRes = pairShift[XLEN-1:0];
      OP_BPICK:  selRes = bpickRes;
      OP_INSB:   selRes = insbRes;
      OP_MAC:    selRes = rdOld + prodLo;
      default:   selRes = rdOld - prodLo;
    endcase
  end

  assign result = strobe.wen ? selRes : '0;

  assert_brev_high_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wen && strobe.kind == OP_BREV) |-> (((result >> amt) >> 1) == '0));
  assert_insb_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wen && strobe.kind == OP_INSB)
      |-> (((result ^ rdOld) & ~({{(XLEN-8){1'b0}}, 8'hff} << (8 * strobe.byteSel))) == '0));
  assert_rshift_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wen && strobe.kind == OP_RSHIFT && amt == '0) |-> (result == opA));
  assert_avg_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wen && strobe.kind == OP_AVG && opA == opB) |-> (result == opA));
endmodule

// File: rtl/dspmisc_alu.sv
module dspmisc_alu
  import dspmisc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] insn,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] opC,
  input  logic [31:0] rdOld,
  input  logic [31:0] opAHi,
  output logic [31:0] result,
  output logic        writeEn,
  output logic        illegal
);
  ctrlStrobe_t     strobe;
  logic [XLEN-1:0] dpResult;

  dspmisc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .insn    (insn),
    .strobe  (strobe)
  );

  dspmisc_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .rdOld  (rdOld),
    .opAHi  (opAHi),
    .result (dpResult)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        result  <= '0;
        writeEn <= 1'b0;
        illegal <= 1'b0;
      end else begin
        result  <= dpResult;
        writeEn <= strobe.wen;
        illegal <= strobe.illegal;
      end
    end

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
      (writeEn || illegal) |-> $past(inValid));
  end else begin : g_comb
    assign result  = dpResult;
    assign writeEn = strobe.wen;
    assign illegal = strobe.illegal;
  end

  assert_quiet_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |-> (result == '0));
endmodule

// File: tb/dspmisc_alu_tb.sv
module dspmisc_alu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0, opA = '0, opB = '0, opC = '0, rdOld = '0, opAHi = '0;
  logic [31:0] result;
  logic        writeEn, illegal;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit          we;
    bit          il;
    logic [31:0] res;
    string       ctlReq;
    string       resReq;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  dspmisc_alu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn),
    .opA(opA), .opB(opB), .opC(opC), .rdOld(rdOld), .opAHi(opAHi),
    .result(result), .writeEn(writeEn), .illegal(illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference
  task automatic model(input bit v, input logic [31:0] w, a, b, c, rd, hi, output exp_t e);
    logic [6:0] f7;
    logic [2:0] f3;
    longint s, x;
    int amt;
    logic [63:0] pair;
    f7 = w[31:25];
    f3 = w[14:12];
    e.we = 0; e.il = 0; e.res = 0; e.ctlReq = "R10"; e.resReq = "R10";
    if (!v || w[6:0] != 7'h7f) return;
    e.we = 1; e.ctlReq = "R1";
    if (f3 == 3'd3) begin
      if (w[26:25] != 2'b00) begin
        e.we = 0;
      end else begin
        e.resReq = "R6"; e.res = (c & a) | (~c & b);
      end
    end else if (f7 == 7'b1110000 && f3 == 0) begin
      e.resReq = "R2";
      s = longint'($signed(a)) + longint'($signed(b)) + 1;
      s = s >>> 1;
      e.res = s[31:0];
    end else if ((f7 == 7'b0010010 || f7[6:1] == 6'b110101) && f3 == 1) begin
      e.resReq = "R3";
      amt = (f7 == 7'b0010010) ? int'(b[4:0]) : int'(w[24:20]);
      x = longint'($signed(a));
      if (amt == 0) e.res = a;
      else begin
        s = (x >>> amt) + ((x >>> (amt - 1)) & 1);
        e.res = s[31:0];
      end
    end else if ((f7 == 7'b1110011 || f7[6:1] == 6'b111010) && f3 == 0) begin
      e.resReq = "R4";
      amt = (f7 == 7'b1110011) ? int'(b[4:0]) : int'(w[24:20]);
      for (int i = 0; i <= amt; i++) e.res[i] = a[amt - i];
    end else if ((f7 == 7'b1100111 || f7 == 7'b1101111) && f3 == 0) begin
      e.resReq = "R5";
      amt = (f7 == 7'b1100111) ? int'(b[4:0]) : int'(w[24:20]);
      pair = {hi, a};
      pair = pair >> amt;
      e.res = pair[31:0];
    end else if (w[31:23] == 9'b101011000 && f3 == 0) begin
      e.resReq = "R7";
      e.res = rd;
      e.res[8 * int'(w[21:20]) +: 8] = a[7:0];
    end else if (f7 == 7'b1100010 && f3 == 1) begin
      e.resReq = "R8"; e.res = rd + a * b;
    end else if (f7 == 7'b1100011 && f3 == 1) begin
      e.resReq = "R8"; e.res = rd - a * b;
    end else begin
      e.we = 0;
    end
    if (!e.we) begin
      e.il = 1; e.ctlReq = "R9"; e.resReq = "R9";
    end
  endtask

  task automatic checkPending();
    exp_t e;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    check(e.ctlReq, {31'd0, writeEn}, {31'd0, e.we});
    check(e.ctlReq, {31'd0, illegal}, {31'd0, e.il});
    check(e.resReq, result, e.res);
  endtask

  task automatic step(input bit v, input logic [31:0] w, a, b, c, rd, hi);
    exp_t e;
    @(negedge clk);
    checkPending();  // R11: one register stage
    inValid = v; insn = w; opA = a; opB = b; opC = c; rdOld = rd; opAHi = hi;
    model(v, w, a, b, c, rd, hi, e);
    expQ.push_back(e);
  endtask

  function automatic logic [31:0] mkInsn(int cls);
    logic [31:0] w;
    w = $urandom;
    w[6:0] = 7'h7f;
    case (cls)
      0:  begin w[31:25] = 7'b1110000; w[14:12] = 3'd0; end
      1:  begin w[31:25] = 7'b0010010; w[14:12] = 3'd1; end
      2:  begin w[31:26] = 6'b110101;  w[14:12] = 3'd1; end
      3:  begin w[31:25] = 7'b1110011; w[14:12] = 3'd0; end
      4:  begin w[31:26] = 6'b111010;  w[14:12] = 3'd0; end
      5:  begin w[31:25] = 7'b1100111; w[14:12] = 3'd0; end
      6:  begin w[31:25] = 7'b1101111; w[14:12] = 3'd0; end
      7:  begin w[26:25] = 2'b00;      w[14:12] = 3'd3; end
      8:  begin w[31:23] = 9'b101011000; w[14:12] = 3'd0; end
      9:  begin w[31:25] = 7'b1100010; w[14:12] = 3'd1; end
      10: begin w[31:25] = 7'b1100011; w[14:12] = 3'd1; end
      11: begin w[25] = 1'b1;          w[14:12] = 3'd3; end
      12: w[6:0] = 7'h33;
      default: ;
    endcase
    return w;
  endfunction

  function automatic logic [31:0] rInsn(logic [6:0] f7, logic [2:0] f3);
    return {f7, 10'h2a5, f3, 5'd3, 7'h7f};
  endfunction

  function automatic logic [31:0] iInsn(logic [6:0] f7, logic [4:0] sh, logic [2:0] f3);
    return {f7, sh, 5'd4, f3, 5'd3, 7'h7f};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", result, 32'd0);
    check("R11", {31'd0, writeEn}, 32'd0);
    check("R11", {31'd0, illegal}, 32'd0);
    rstN = 1'b1;

    // R2 extremes
    step(1, rInsn(7'b1110000, 0), 32'h80000000, 32'h80000000, 0, 0, 0);
    step(1, rInsn(7'b1110000, 0), 32'h7fffffff, 32'h7fffffff, 0, 0, 0);
    step(1, rInsn(7'b1110000, 0), 32'h7fffffff, 32'h80000000, 0, 0, 0);
    step(1, rInsn(7'b1110000, 0), 32'hffffffff, 32'h00000002, 0, 0, 0);
    // R3 amounts 0 and 31, both forms, upper amount bits ignored
    step(1, rInsn(7'b0010010, 1), 32'h80000001, 32'hffffffe0, 0, 0, 0);
    step(1, rInsn(7'b0010010, 1), 32'h80000000, 32'd31, 0, 0, 0);
    step(1, rInsn(7'b0010010, 1), 32'h40000000, 32'd31, 0, 0, 0);
    step(1, iInsn(7'b1101010, 5'd31, 1), 32'hc0000000, 0, 0, 0, 0);
    step(1, iInsn(7'b1101011, 5'd1, 1), 32'h7fffffff, 0, 0, 0, 0);
    // R4 s=31 and s=0
    step(1, rInsn(7'b1110011, 0), 32'h12345678, 32'd31, 0, 0, 0);
    step(1, iInsn(7'b1110100, 5'd0, 0), 32'hfffffffe, 0, 0, 0, 0);
    step(1, iInsn(7'b1110101, 5'd7, 0), 32'hffffff01, 0, 0, 0, 0);
    // R5 lsb 0 and 31
    step(1, rInsn(7'b1100111, 0), 32'hdeadbeef, 32'd0, 0, 0, 32'h01234567);
    step(1, rInsn(7'b1100111, 0), 32'hdeadbeef, 32'd31, 0, 0, 32'h01234567);
    step(1, iInsn(7'b1101111, 5'd16, 0), 32'haaaa5555, 0, 0, 0, 32'h3333cccc);
    // R6 bit-pick and its illegal variant
    step(1, {5'd9, 2'b00, 5'd2, 5'd1, 3'd3, 5'd3, 7'h7f}, 32'hffff0000, 32'h00ff00ff, 32'h0f0f0f0f, 0, 0);
    step(1, {5'd9, 2'b10, 5'd2, 5'd1, 3'd3, 5'd3, 7'h7f}, 32'hffff0000, 32'h00ff00ff, 32'h0f0f0f0f, 0, 0);
    // R7 every byte, upper shamt bit ignored
    for (int k = 0; k < 8; k++)
      step(1, {9'b101011000, k[2:0], 5'd1, 3'd0, 5'd3, 7'h7f}, 32'h000000a5, 0, 0, 32'h11223344, 0);
    // R8 wrap
    step(1, rInsn(7'b1100010, 1), 32'hffffffff, 32'hffffffff, 0, 32'hffffffff, 0);
    step(1, rInsn(7'b1100011, 1), 32'h00010000, 32'h00010000, 0, 32'd5, 0);
    // R9 / R10
    step(1, rInsn(7'b0000001, 7), 1, 2, 3, 4, 5);
    step(0, rInsn(7'b1110000, 0), 1, 2, 3, 4, 5);
    step(1, {25'h1abcdef, 7'h33}, 1, 2, 3, 4, 5);

    for (int n = 0; n < 4000; n++)
      step(($urandom % 8) != 0, mkInsn($urandom % 15), $urandom, $urandom, $urandom,
           $urandom, $urandom);

    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    checkPending();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule